// File: doc/BRIEF.md
# Multistage Radix-2 Propagation Network

This block carries tagged data from N input channels to N output channels, with N a power of two. It replaces one wide crossbar with log2(N) buffered stages. Each stage is a row of two-input, two-output switch elements. Every element holds two queues, one for each of its outputs. Each queue can take up to two writes and give one read per clock cycle. A datum carries its destination channel index with it. Each stage looks at one bit of that index, starting with the most significant bit, and moves the datum one step closer to its output.

Every input and every output has a valid/ready handshake. An input is held back only when the queue its datum needs is short of space. A datum waiting at the head of one queue never blocks the other queue in the same element, so traffic to other outputs keeps moving. Each stage adds one cycle of latency in exchange for simple, local wiring.

Top module: `prop_network`

## Requirements
- R1: A datum accepted on any input with destination d leaves only on output d. There `out_dest` equals d and the payload is unchanged. Destinations are `in_dest` slice `[c*log2(N) +: log2(N)]` and payloads are `in_data` slice `[c*DATA_W +: DATA_W]`.
- R2: Every accepted datum is delivered exactly once, and no output is ever valid while the network holds nothing.
- R3: Data sent from one input to one output arrive in the order they were accepted.
- R4: When both inputs of a switch element write into the same queue in the same cycle, the datum from the lower-indexed channel is delivered first.
- R5: A queue accepts a write only while at least two of its DEPTH entries are free. A single flow into a blocked output is therefore accepted exactly log2(N)*(DEPTH-1) times before its input ready drops.
- R6: A blocked output does not hold back data from the same input, or from other inputs, that is headed to a different output through non-full queues.
- R7: While an output is valid and not ready, its valid, destination and payload stay unchanged.
- R8: After reset no output is valid and every input is ready.
- R9: A datum entering an empty network with all outputs ready appears on its output log2(N) clock edges after the edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-input datum valid |
| in_dest | input | N*log2(N) | Per-input destination channel index |
| in_data | input | N*DATA_W | Per-input payload |
| in_ready | output | N | Per-input accept, depends on that input's destination |
| out_valid | output | N | Per-output datum valid |
| out_dest | output | N*log2(N) | Destination index carried with each delivered datum |
| out_data | output | N*DATA_W | Per-output payload |
| out_ready | input | N | Per-output consumer ready |

## Verification
The assertions check on every cycle that outputs only carry data addressed to them, that stalled outputs hold still, that an empty network shows no valid output, that the count of data in flight never exceeds the total storage, and that the network starts idle after reset. Ordering within each input/output flow, the lower-index-first rule for same-cycle writes, the exact fill count against a blocked output, independence from head-of-line blocking, and the per-stage latency all depend on sequences of traffic. Only the bench's scenarios can show these. It sweeps every input/output pair at full and throttled output rates, and its scoreboard tracks sequence numbers.

// File: rtl/prop_net_pkg.sv
package prop_net_pkg;

    // Lower channel of switch element `elem` in stage `stage` (0-based).
    // Partner is lower + (n >> (stage + 1)).
    function automatic int pair_low(int n, int stage, int elem);
        int step;
        step = n >> (stage + 1);
        return (elem / step) * 2 * step + (elem % step);
    endfunction

    // Destination bit steered in stage `stage`: most significant first.
    function automatic int steer_bit(int levels, int stage);
        return levels - 1 - stage;
    endfunction

endpackage

// File: rtl/dual_write_fifo.sv
module dual_write_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_en,
    input  logic [WIDTH-1:0] wr_data0,
    input  logic [WIDTH-1:0] wr_data1,
    output logic             can_accept,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_en
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] count;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [WIDTH-1:0] mem [DEPTH];

    logic [1:0]       n_wr;
    logic             pop;
    logic [PW-1:0]    wa0, wa1;
    logic [WIDTH-1:0] wd0;
    logic             we0, we1;

    function automatic logic [PW-1:0] wrap_add(logic [PW-1:0] p, logic [1:0] inc);
        int unsigned t;
        t = int'(p) + int'(inc);
        if (t >= DEPTH) t = t - DEPTH;
        return PW'(t);
    endfunction

    always_comb begin
        n_wr       = {1'b0, wr_en[0]} + {1'b0, wr_en[1]};
        pop        = rd_en && (ctl_q.count != '0);
        can_accept = (int'(DEPTH) - int'(ctl_q.count)) >= 2;
        rd_valid   = (ctl_q.count != '0);
        rd_data    = mem[ctl_q.rptr];

        // lower-indexed writer takes the first slot
        wa0 = ctl_q.wptr;
        wa1 = wrap_add(ctl_q.wptr, 2'd1);
        wd0 = wr_en[0] ? wr_data0 : wr_data1;
        we0 = (n_wr != 2'd0);
        we1 = (n_wr == 2'd2);

        ctl_d       = ctl_q;
        ctl_d.wptr  = wrap_add(ctl_q.wptr, n_wr);
        ctl_d.rptr  = wrap_add(ctl_q.rptr, {1'b0, pop});
        ctl_d.count = ctl_q.count + CW'(n_wr) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we0) mem[wa0] <= wd0;
        if (we1) mem[wa1] <= wr_data1;
    end

endmodule

// File: rtl/prop_switch.sv
module prop_switch #(
    parameter int FW    = 18,
    parameter int DEPTH = 160,
    parameter int SEL   = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          in_valid,
    input  logic [1:0][FW-1:0]  in_flit,
    output logic [1:0]          in_ready,
    output logic [1:0]          out_valid,
    output logic [1:0][FW-1:0]  out_flit,
    input  logic [1:0]          out_ready
);
    logic [1:0]      acc;
    logic [1:0][1:0] we;

    always_comb begin
        for (int q = 0; q < 2; q++) begin
            for (int p = 0; p < 2; p++) begin
                we[q][p] = in_valid[p] && (in_flit[p][SEL] == q[0]) && acc[q];
            end
        end
        for (int p = 0; p < 2; p++) begin
            in_ready[p] = acc[in_flit[p][SEL]];
        end
    end

    for (genvar q = 0; q < 2; q++) begin : g_queue
        dual_write_fifo #(
            .WIDTH (FW),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (we[q]),
            .wr_data0   (in_flit[0]),
            .wr_data1   (in_flit[1]),
            .can_accept (acc[q]),
            .rd_valid   (out_valid[q]),
            .rd_data    (out_flit[q]),
            .rd_en      (out_ready[q])
        );
    end

endmodule

// File: rtl/prop_network.sv
module prop_network #(
    parameter int N      = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 160
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               in_valid,
    input  logic [N*$clog2(N)-1:0]     in_dest,
    input  logic [N*DATA_W-1:0]        in_data,
    output logic [N-1:0]               in_ready,
    output logic [N-1:0]               out_valid,
    output logic [N*$clog2(N)-1:0]     out_dest,
    output logic [N*DATA_W-1:0]        out_data,
    input  logic [N-1:0]               out_ready
);
    localparam int AW     = $clog2(N);
    localparam int STAGES = AW;
    localparam int FW     = DATA_W + AW;
    localparam int HALF   = N / 2;

    // level 0 = inputs, level STAGES = outputs; flit = {payload, dest}
    logic [STAGES:0][N-1:0]         lvl_valid;
    logic [STAGES:0][N-1:0]         lvl_ready;
    logic [STAGES:0][N-1:0][FW-1:0] lvl_flit;

    for (genvar c = 0; c < N; c++) begin : g_edge
        assign lvl_valid[0][c] = in_valid[c];
        assign lvl_flit[0][c]  = {in_data[c*DATA_W +: DATA_W], in_dest[c*AW +: AW]};
        assign in_ready[c]     = lvl_ready[0][c];

        assign out_valid[c]               = lvl_valid[STAGES][c];
        assign out_dest[c*AW +: AW]       = lvl_flit[STAGES][c][AW-1:0];
        assign out_data[c*DATA_W +: DATA_W] = lvl_flit[STAGES][c][FW-1:AW];
        assign lvl_ready[STAGES][c]       = out_ready[c];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar e = 0; e < HALF; e++) begin : g_elem
            localparam int LO  = prop_net_pkg::pair_low(N, s, e);
            localparam int HI  = LO + (N >> (s + 1));
            localparam int SEL = prop_net_pkg::steer_bit(AW, s);

            logic [1:0]         v_in, r_in, v_out, r_out;
            logic [1:0][FW-1:0] f_in, f_out;

            assign v_in  = {lvl_valid[s][HI], lvl_valid[s][LO]};
            assign f_in  = {lvl_flit[s][HI], lvl_flit[s][LO]};
            assign lvl_ready[s][LO] = r_in[0];
            assign lvl_ready[s][HI] = r_in[1];

            assign lvl_valid[s+1][LO] = v_out[0];
            assign lvl_valid[s+1][HI] = v_out[1];
            assign lvl_flit[s+1][LO]  = f_out[0];
            assign lvl_flit[s+1][HI]  = f_out[1];
            assign r_out = {lvl_ready[s+1][HI], lvl_ready[s+1][LO]};

            prop_switch #(
                .FW    (FW),
                .DEPTH (DEPTH),
                .SEL   (SEL)
            ) u_sw (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (v_in),
                .in_flit   (f_in),
                .in_ready  (r_in),
                .out_valid (v_out),
                .out_flit  (f_out),
                .out_ready (r_out)
            );
        end
    end

endmodule

// File: rtl/prop_network_chk.sv
module prop_network_chk #(
    parameter int N      = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 160
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           in_valid,
    input logic [N-1:0]           in_ready,
    input logic [N-1:0]           out_valid,
    input logic [N*$clog2(N)-1:0] out_dest,
    input logic [N*DATA_W-1:0]    out_data,
    input logic [N-1:0]           out_ready
);
    localparam int AW  = $clog2(N);
    localparam int CAP = AW * N * DEPTH;
    localparam int IW  = $clog2(CAP + 1) + 1;

    logic [IW-1:0] inflight_q;
    logic          first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight_q <= '0;
            first_q    <= 1'b1;
        end else begin
            inflight_q <= inflight_q + IW'($countones(in_valid & in_ready))
                                     - IW'($countones(out_valid & out_ready));
            first_q    <= 1'b0;
        end
    end

    assert_reset_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (out_valid == '0 && in_ready == '1));

    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q == '0) |-> (out_valid == '0));

    assert_bounded_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(inflight_q) <= CAP);

    for (genvar k = 0; k < N; k++) begin : g_out
        assert_dest_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> (out_dest[k*AW +: AW] == AW'(k)));

        assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && !out_ready[k]) |=>
                (out_valid[k] && $stable(out_data[k*DATA_W +: DATA_W])
                              && $stable(out_dest[k*AW +: AW])));
    end

endmodule

bind prop_network prop_network_chk #(
    .N      (N),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/prop_network_tb.sv
`timescale 1ns/1ps
module prop_network_tb;
    localparam int N = 4, AW = 2, DW = 16, DEPTH = 4, S = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0]    in_valid, in_ready, out_valid, out_ready;
    logic [N*AW-1:0] in_dest, out_dest;
    logic [N*DW-1:0] in_data, out_data;

    always #2 clk = ~clk;

    prop_network #(.N(N), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data), .out_ready(out_ready)
    );

    int checks = 0, errors = 0;
    int q_dest [N][64];
    int q_len [N], q_pos [N], acc_step [N];
    int tx_seq [N][N], rx_seq [N][N];
    int log_src [N][64];
    int log_n [N], last_out_step [N];
    int total_tx = 0, total_rx = 0, step_no = 0;
    int rdy_mode = 0;
    logic [N-1:0] rdy_mask = '1, last_in_ready = '0, last_out_valid = '0;
    logic [DW-1:0] last_out0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_phase();
        for (int i = 0; i < N; i++) begin
            q_len[i] = 0; q_pos[i] = 0; log_n[i] = 0;
        end
    endtask

    task automatic step();
        logic [N-1:0] fin;
        int fd [N];
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            fd[i] = 0;
            if (q_pos[i] < q_len[i]) begin
                fd[i] = q_dest[i][q_pos[i]];
                in_valid[i] = 1'b1;
                in_dest[i*AW +: AW] = AW'(fd[i]);
                in_data[i*DW +: DW] = DW'((i << 8) | (tx_seq[i][fd[i]] & 255));
            end else begin
                in_valid[i] = 1'b0;
            end
        end
        if (rdy_mode == 0) out_ready = '1;
        else if (rdy_mode == 1) out_ready = lfsr[3:0] | lfsr[7:4];
        else out_ready = rdy_mask;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        for (int k = 0; k < N; k++) begin
            if (out_valid[k] && out_ready[k]) begin
                logic [DW-1:0] od;
                int src, sq;
                od  = out_data[k*DW +: DW];
                src = int'(od[9:8]);
                sq  = int'(od[7:0]);
                check(out_dest[k*AW +: AW] == AW'(k), "R1", "out_dest on output", int'(out_dest[k*AW +: AW]), k);
                check(od[15:10] == '0, "R1", "payload upper bits", int'(od[15:10]), 0);
                check(sq == (rx_seq[src][k] & 255), "R3", "flow sequence", sq, rx_seq[src][k] & 255);
                rx_seq[src][k]++;
                total_rx++;
                if (log_n[k] < 64) log_src[k][log_n[k]] = src;
                log_n[k]++;
                last_out_step[k] = step_no;
            end
        end
        fin = in_valid & in_ready;
        last_in_ready  = in_ready;
        last_out_valid = out_valid;
        last_out0      = out_data[DW-1:0];
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (fin[i]) begin
                tx_seq[i][fd[i]]++;
                q_pos[i]++;
                total_tx++;
                acc_step[i] = step_no;
            end
        end
        step_no++;
    endtask

    function automatic bit idle();
        for (int i = 0; i < N; i++) if (q_pos[i] < q_len[i]) return 1'b0;
        return total_rx == total_tx;
    endfunction

    task automatic run_idle(int limit);
        int n = 0;
        while (!idle() && n < limit) begin
            step();
            n++;
        end
        check(idle(), "R2", "network drained", total_rx, total_tx);
    endtask

    task automatic load_sweep();
        clear_phase();
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < 24; j++) q_dest[i][j] = (i + j + j / N) % N;
            q_len[i] = 24;
        end
    endtask

    task automatic check_pairs(string tag);
        for (int i = 0; i < N; i++)
            for (int d = 0; d < N; d++)
                check(rx_seq[i][d] == tx_seq[i][d], "R2", tag, rx_seq[i][d], tx_seq[i][d]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] held;
        in_valid = '0; in_dest = '0; in_data = '0; out_ready = '0; rst_n = 1'b0;
        for (int i = 0; i < N; i++)
            for (int d = 0; d < N; d++) begin
                tx_seq[i][d] = 0; rx_seq[i][d] = 0;
            end
        clear_phase();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R8: idle after reset
        check(out_valid == '0, "R8", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == '1, "R8", "in_ready after reset", int'(in_ready), 15);

        // R9: latency equals stage count
        clear_phase();
        q_dest[1][0] = 2; q_len[1] = 1;
        rdy_mode = 0;
        run_idle(50);
        check(log_n[2] == 1, "R9", "single datum delivered", log_n[2], 1);
        check(last_out_step[2] - acc_step[1] == S, "R9", "latency in edges",
              last_out_step[2] - acc_step[1], S);

        // R1 R2 R3: full-rate sweep over every pair
        load_sweep();
        rdy_mode = 0;
        run_idle(2000);
        check_pairs("full-rate pair count");

        // R1 R2 R3: throttled sweep
        load_sweep();
        rdy_mode = 1;
        run_idle(5000);
        check_pairs("throttled pair count");

        // R4: same-cycle writes into one queue, lower channel first
        clear_phase();
        rdy_mode = 0;
        q_dest[0][0] = 0; q_len[0] = 1;
        q_dest[2][0] = 0; q_len[2] = 1;
        q_dest[1][0] = 2; q_len[1] = 1;
        q_dest[3][0] = 2; q_len[3] = 1;
        run_idle(50);
        check(log_n[0] == 2, "R4", "out0 count", log_n[0], 2);
        check(log_src[0][0] == 0 && log_src[0][1] == 2, "R4", "out0 first source",
              log_src[0][0], 0);
        check(log_n[2] == 2, "R4", "out2 count", log_n[2], 2);
        check(log_src[2][0] == 1 && log_src[2][1] == 3, "R4", "out2 first source",
              log_src[2][0], 1);

        // R5: single flow into a blocked output
        clear_phase();
        rdy_mode = 2; rdy_mask = '0;
        for (int j = 0; j < 20; j++) q_dest[0][j] = 0;
        q_len[0] = 20;
        repeat (30) step();
        check(q_pos[0] == S * (DEPTH - 1), "R5", "accepted before ready drops", q_pos[0], S * (DEPTH - 1));
        check(last_in_ready[0] == 1'b0, "R5", "in_ready with full path", int'(last_in_ready[0]), 0);
        check(last_out_valid[0] == 1'b1, "R7", "blocked output valid", int'(last_out_valid[0]), 1);
        held = last_out0;

        // R6: other destinations still flow past the blocked output
        q_len[0] = q_pos[0];
        q_dest[0][q_len[0]] = 3; q_len[0]++;
        q_dest[1][0] = 2; q_len[1] = 1;
        rdy_mask = 4'b1100;
        repeat (8) step();
        check(q_pos[0] == q_len[0], "R6", "same input other output accepted", q_pos[0], q_len[0]);
        check(log_n[3] == 1 && log_src[3][0] == 0, "R6", "datum reached out3", log_n[3], 1);
        check(log_n[2] == 1 && log_src[2][0] == 1, "R6", "datum reached out2", log_n[2], 1);
        check(log_n[0] == 0, "R7", "blocked output delivered nothing", log_n[0], 0);
        check(last_out_valid[0] == 1'b1, "R7", "still valid while stalled", int'(last_out_valid[0]), 1);
        check(last_out0 == held, "R7", "payload held while stalled", int'(last_out0), int'(held));

        rdy_mask = '1;
        run_idle(200);
        check(log_n[0] == S * (DEPTH - 1), "R5", "blocked flow drained", log_n[0], S * (DEPTH - 1));
        check_pairs("final pair count");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule